// File: doc/BRIEF.md
# Cartridge Bank Switching Register File

This block listens to CPU write cycles on a console bus and keeps the bank registers of a game cartridge. From those registers it produces, every cycle, the ROM bank number that each address window should read from. There are four 8 KB program windows on the CPU side and eight 1 KB character windows on the video side, plus a nametable mirroring select. The ROM arrays, the address multiplexing into them and any interrupt or save-memory logic sit outside the block. The block only supplies bank numbers.

Writes in the upper half of the CPU space go to one of three slots: a bank-select slot, a bank-data slot and a mirroring slot. The select slot picks which bank register the next data write loads. Two bits of the select byte also choose between two program window orderings and two character layouts. Writes to a low expansion range (0x4100 to 0x7FFF) reprogram the first two program windows as one consecutive 16 KB pair in a single step. Both bank counts are parameters and must be powers of two. The fixed windows track the last two program banks of the configured size.

Top module: `cbk_bank_regs`

## Requirements
- R1: Writes with bus_addr[15]=1 are decoded only through bus_addr & 0xE001. Value 0x8000 is the select slot, 0x8001 the data slot and 0xA000 the mirroring slot. Every other decoded value (0xA001, 0xC000, 0xC001, 0xE000, 0xE001) changes no output.
- R2: A select-slot write stores the whole byte. Its bits [2:0] name the register that later data-slot writes load: 0 and 1 are character pairs A and B, 2 to 5 are single character banks 0 to 3, 6 is program bank A and 7 is program bank B.
- R3: A data write to index 0 or 1 stores the byte with bit 0 cleared. The pair then drives two adjacent 1 KB windows with banks v and v+1.
- R4: A data write to an index from 2 to 5 loads one single 1 KB character bank. A data write to index 6 or 7 loads program bank A or B.
- R5: With select bit 6 = 0, the program windows 0..3 show A, B, N-2, N-1. With bit 6 = 1 they show N-2, B, A, N-1, where N is the program bank count.
- R6: With select bit 7 = 0, character windows 0..7 show A, A+1, B, B+1, S0, S1, S2, S3. With bit 7 = 1 the two 4 KB halves are exchanged: S0..S3 in windows 0..3 and the pairs in windows 4..7.
- R7: A mirroring-slot write sets mirror_horiz to data bit 0 (1 = horizontal, 0 = vertical). When four_screen is 1, the write leaves mirror_horiz unchanged.
- R8: A write with an address from 0x4100 to 0x7FFF and data d makes windows 0 and 1 show 2d and 2d+1 (mod N), and windows 2 and 3 show N-2 and N-1, whatever select bit 6 is. This override stays through character, mirroring and ignored writes. It ends on the next select-slot write or the next data write to index 6 or 7. Low addresses outside that range are ignored.
- R9: After reset, program banks A and B are 0 and 1, pairs A and B are 0 and 2, singles S0..S3 are 4, 5, 6 and 7, the select byte is 0, mirror_horiz is 0 and no override is active.
- R10: Each bank output is the stored value modulo the bank count. Window 3 always shows N-1.
- R11: Each write changes the outputs from the first clock edge that samples it. Outputs do not change in a cycle that has no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | CPU write strobe, one write per cycle when high |
| bus_addr | input | 16 | CPU write address |
| bus_wdata | input | 8 | CPU write data |
| four_screen | input | 1 | Strap: 1 blocks mirroring writes |
| prg_win | output | 4 x PRG_W | Program bank for CPU windows 0..3 |
| chr_win | output | 8 x CHR_W | Character bank for video windows 0..7 |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
Two functions can fall together. The low-range override can be active while the stored program registers and select bit 6 call for a different ordering. A single select-slot write can also change the program ordering and the character layout at once. The bench first sets bit 6 and loads both program registers, then applies a low-range write and confirms that the pair 2d/2d+1 wins. It then interleaves character and mirroring writes, which must leave the override in place. Last, it checks that a select write or a program-index data write restores the register-driven ordering on the very next sample.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

    localparam logic [15:0] SLOT_MASK    = 16'hE001;
    localparam logic [15:0] SLOT_SELECT_A = 16'h8000;
    localparam logic [15:0] SLOT_DATA_A   = 16'h8001;
    localparam logic [15:0] SLOT_MIRROR_A = 16'hA000;
    localparam logic [15:0] LOW_FIRST     = 16'h4100;
    localparam logic [15:0] LOW_LAST      = 16'h7FFF;

    localparam int PRG_SWAP_BIT = 6;
    localparam int CHR_SWAP_BIT = 7;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_SELECT,
        SLOT_DATA,
        SLOT_MIRROR,
        SLOT_LOW
    } slot_e;

    typedef enum logic [2:0] {
        TGT_PAIR_A = 3'd0,
        TGT_PAIR_B = 3'd1,
        TGT_ONE_0  = 3'd2,
        TGT_ONE_1  = 3'd3,
        TGT_ONE_2  = 3'd4,
        TGT_ONE_3  = 3'd5,
        TGT_PRG_A  = 3'd6,
        TGT_PRG_B  = 3'd7
    } target_e;

    typedef struct packed {
        logic [7:0]      select;
        logic [7:0]      prg_a;
        logic [7:0]      prg_b;
        logic [7:0]      pair_a;
        logic [7:0]      pair_b;
        logic [3:0][7:0] single;
        logic            horiz;
        logic            low_act;
        logic [7:0]      low_val;
    } bank_state_t;

    function automatic slot_e decode_slot(input logic we, input logic [15:0] addr);
        slot_e s;
        s = SLOT_NONE;
        if (we) begin
            if (addr[15]) begin
                case (addr & SLOT_MASK)
                    SLOT_SELECT_A: s = SLOT_SELECT;
                    SLOT_DATA_A:   s = SLOT_DATA;
                    SLOT_MIRROR_A: s = SLOT_MIRROR;
                    default:       s = SLOT_NONE;
                endcase
            end else if (addr >= LOW_FIRST && addr <= LOW_LAST) begin
                s = SLOT_LOW;
            end
        end
        return s;
    endfunction

    function automatic bank_state_t reset_state();
        bank_state_t r;
        r.select    = 8'h00;
        r.prg_a     = 8'd0;
        r.prg_b     = 8'd1;
        r.pair_a    = 8'd0;
        r.pair_b    = 8'd2;
        r.single[0] = 8'd4;
        r.single[1] = 8'd5;
        r.single[2] = 8'd6;
        r.single[3] = 8'd7;
        r.horiz     = 1'b0;
        r.low_act   = 1'b0;
        r.low_val   = 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/cbk_decode.sv
module cbk_decode
    import cbk_pkg::*;
(
    input  logic        we,
    input  logic [15:0] addr,
    output slot_e       slot
);
    always_comb begin
        slot = decode_slot(we, addr);
    end
endmodule

// File: rtl/cbk_update.sv
module cbk_update
    import cbk_pkg::*;
(
    input  slot_e       slot,
    input  logic [7:0]  wdata,
    input  logic        four_screen,
    input  bank_state_t cur,
    output bank_state_t nxt
);
    target_e tgt;

    always_comb begin
        tgt = target_e'(cur.select[2:0]);
        nxt = cur;
        case (slot)
            SLOT_SELECT: begin
                nxt.select  = wdata;
                nxt.low_act = 1'b0;
            end
            SLOT_DATA: begin
                case (tgt)
                    TGT_PAIR_A: nxt.pair_a    = {wdata[7:1], 1'b0};
                    TGT_PAIR_B: nxt.pair_b    = {wdata[7:1], 1'b0};
                    TGT_ONE_0:  nxt.single[0] = wdata;
                    TGT_ONE_1:  nxt.single[1] = wdata;
                    TGT_ONE_2:  nxt.single[2] = wdata;
                    TGT_ONE_3:  nxt.single[3] = wdata;
                    TGT_PRG_A: begin
                        nxt.prg_a   = wdata;
                        nxt.low_act = 1'b0;
                    end
                    TGT_PRG_B: begin
                        nxt.prg_b   = wdata;
                        nxt.low_act = 1'b0;
                    end
                    default: ;
                endcase
            end
            SLOT_MIRROR: begin
                if (!four_screen) nxt.horiz = wdata[0];
            end
            SLOT_LOW: begin
                nxt.low_act = 1'b1;
                nxt.low_val = wdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cbk_prg_map.sv
module cbk_prg_map
    import cbk_pkg::*;
#(
    parameter int PRG_W = 4
) (
    input  bank_state_t            st,
    output logic [3:0][PRG_W-1:0]  win
);
    logic [PRG_W-1:0] last_b;
    logic [PRG_W-1:0] penult_b;
    logic [PRG_W-1:0] bank_a;
    logic [PRG_W-1:0] bank_b;
    logic [PRG_W-1:0] low_even;
    logic [8:0]       low_dbl;
    logic             unused_bits;

    assign unused_bits = ^st;

    always_comb begin
        last_b   = '1;
        penult_b = {{(PRG_W-1){1'b1}}, 1'b0};
        bank_a   = st.prg_a[PRG_W-1:0];
        bank_b   = st.prg_b[PRG_W-1:0];
        low_dbl  = {st.low_val, 1'b0};
        low_even = low_dbl[PRG_W-1:0];
        win[3]   = last_b;
        win[2]   = penult_b;
        if (st.low_act) begin
            win[0] = low_even;
            win[1] = low_even | PRG_W'(1);
        end else if (st.select[PRG_SWAP_BIT]) begin
            win[0] = penult_b;
            win[1] = bank_b;
            win[2] = bank_a;
        end else begin
            win[0] = bank_a;
            win[1] = bank_b;
        end
    end
endmodule

// File: rtl/cbk_chr_map.sv
module cbk_chr_map
    import cbk_pkg::*;
#(
    parameter int CHR_W = 7
) (
    input  bank_state_t            st,
    output logic [7:0][CHR_W-1:0]  win
);
    logic [7:0][7:0] src;
    logic            swap;
    logic            unused_bits;

    assign unused_bits = ^st;
    assign swap        = st.select[CHR_SWAP_BIT];

    assign src[0] = st.pair_a;
    assign src[1] = st.pair_a | 8'h01;
    assign src[2] = st.pair_b;
    assign src[3] = st.pair_b | 8'h01;

    genvar j;
    generate
        for (j = 0; j < 4; j++) begin : g_single
            assign src[4+j] = st.single[j];
        end
    endgenerate

    genvar i;
    generate
        for (i = 0; i < 8; i++) begin : g_win
            localparam int OTHER = (i + 4) % 8;
            assign win[i] = swap ? src[OTHER][CHR_W-1:0] : src[i][CHR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cbk_bank_regs.sv
module cbk_bank_regs
    import cbk_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    parameter int CHR_BANKS = 128,
    localparam int PRG_W = $clog2(PRG_BANKS),
    localparam int CHR_W = $clog2(CHR_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_we,
    input  logic [15:0]            bus_addr,
    input  logic [7:0]             bus_wdata,
    input  logic                   four_screen,
    output logic [3:0][PRG_W-1:0]  prg_win,
    output logic [7:0][CHR_W-1:0]  chr_win,
    output logic                   mirror_horiz
);
    slot_e       slot;
    bank_state_t st_q;
    bank_state_t st_d;

    cbk_decode u_decode (
        .we   (bus_we),
        .addr (bus_addr),
        .slot (slot)
    );

    cbk_update u_update (
        .slot        (slot),
        .wdata       (bus_wdata),
        .four_screen (four_screen),
        .cur         (st_q),
        .nxt         (st_d)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= reset_state();
        else     st_q <= st_d;
    end

    cbk_prg_map #(.PRG_W(PRG_W)) u_prg (
        .st  (st_q),
        .win (prg_win)
    );

    cbk_chr_map #(.CHR_W(CHR_W)) u_chr (
        .st  (st_q),
        .win (chr_win)
    );

    assign mirror_horiz = st_q.horiz;
endmodule

// File: rtl/cbk_checker.sv
module cbk_checker #(
    parameter int PRG_W = 4,
    parameter int CHR_W = 7
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_we,
    input logic [15:0]            bus_addr,
    input logic                   four_screen,
    input logic [3:0][PRG_W-1:0]  prg_win,
    input logic [7:0][CHR_W-1:0]  chr_win,
    input logic                   mirror_horiz
);
    logic low_hit;
    logic mirr_hit;
    assign low_hit  = bus_we && bus_addr >= 16'h4100 && bus_addr <= 16'h7FFF;
    assign mirr_hit = bus_we && bus_addr[15:13] == 3'b101 && !bus_addr[0];

    // R10: final window pinned to the last bank
    a_r10_last_window: assert property (@(posedge clk) disable iff (rst)
        prg_win[3] == {PRG_W{1'b1}});

    // R7: strapped four-screen freezes mirroring
    a_r7_strap_holds_mirror: assert property (@(posedge clk) disable iff (rst)
        (mirr_hit && four_screen) |=> $stable(mirror_horiz));

    // R8: low write yields an even/odd consecutive pair and fixed upper windows
    a_r8_low_pair: assert property (@(posedge clk) disable iff (rst)
        low_hit |=> (prg_win[0][0] == 1'b0) &&
                    (prg_win[1] == PRG_W'(prg_win[0] + 1'b1)) &&
                    (prg_win[2] == {{(PRG_W-1){1'b1}}, 1'b0}));

    // R11: no write, no change
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(prg_win) && $stable(chr_win) && $stable(mirror_horiz));

    // R9: values right after reset
    a_r9_reset_values: assert property (@(posedge clk)
        rst |=> prg_win[0] == '0 && prg_win[1] == PRG_W'(1) &&
                chr_win[0] == '0 && chr_win[3] == CHR_W'(3) &&
                chr_win[4] == CHR_W'(4) && chr_win[7] == CHR_W'(7) &&
                !mirror_horiz);
endmodule

bind cbk_bank_regs cbk_checker #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .four_screen  (four_screen),
    .prg_win      (prg_win),
    .chr_win      (chr_win),
    .mirror_horiz (mirror_horiz)
);

// File: tb/tb_cbk_bank_regs.sv
module tb_cbk_bank_regs;
    localparam int NP = 16;
    localparam int NC = 32;
    localparam int PW = 4;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0] bus_wdata = 8'h00;
    logic four_screen = 1'b0;
    logic [3:0][PW-1:0] prg_win;
    logic [7:0][CW-1:0] chr_win;
    logic mirror_horiz;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // independent model of the requirements
    int m_sel, m_pa, m_pb, m_ca, m_cb, m_low_on, m_low_v, m_mir;
    int m_s[4];

    always #10 clk = ~clk;

    cbk_bank_regs #(.PRG_BANKS(NP), .CHR_BANKS(NC)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .four_screen(four_screen),
        .prg_win(prg_win), .chr_win(chr_win), .mirror_horiz(mirror_horiz)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = 0; m_pa = 0; m_pb = 1; m_ca = 0; m_cb = 2;
        for (int k = 0; k < 4; k++) m_s[k] = 4 + k;
        m_low_on = 0; m_low_v = 0; m_mir = 0;
    endtask

    task automatic model_write(input int a, input int d);
        if (a >= 16'h8000) begin
            case (a & 16'hE001)
                16'h8000: begin m_sel = d; m_low_on = 0; end
                16'h8001: begin
                    case (m_sel & 7)
                        0: m_ca = d & 8'hFE;
                        1: m_cb = d & 8'hFE;
                        2, 3, 4, 5: m_s[(m_sel & 7) - 2] = d;
                        6: begin m_pa = d; m_low_on = 0; end
                        default: begin m_pb = d; m_low_on = 0; end
                    endcase
                end
                16'hA000: if (!four_screen) m_mir = d & 1;
                default: ;
            endcase
        end else if (a >= 16'h4100 && a <= 16'h7FFF) begin
            m_low_on = 1; m_low_v = d;
        end
    endtask

    task automatic check_all(input string req);
        int ep[4];
        int src[8];
        if (m_low_on != 0) begin
            ep[0] = (2 * m_low_v) % NP; ep[1] = (2 * m_low_v + 1) % NP;
            ep[2] = NP - 2;
        end else if ((m_sel & 8'h40) != 0) begin
            ep[0] = NP - 2; ep[1] = m_pb % NP; ep[2] = m_pa % NP;
        end else begin
            ep[0] = m_pa % NP; ep[1] = m_pb % NP; ep[2] = NP - 2;
        end
        ep[3] = NP - 1;
        src[0] = m_ca; src[1] = m_ca + 1; src[2] = m_cb; src[3] = m_cb + 1;
        for (int k = 0; k < 4; k++) src[4 + k] = m_s[k];
        for (int w = 0; w < 4; w++)
            chk(req, $sformatf("prg_win[%0d]", w), int'(prg_win[w]), ep[w]);
        for (int w = 0; w < 8; w++) begin
            int e;
            e = ((m_sel & 8'h80) != 0) ? src[(w + 4) % 8] : src[w];
            chk(req, $sformatf("chr_win[%0d]", w), int'(chr_win[w]), e % NC);
        end
        chk(req, "mirror_horiz", int'(mirror_horiz), m_mir);
    endtask

    // drive on the falling edge; the output sampled one falling edge later
    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 16'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        int dv[8];
        int sel_a[3];
        int dat_a[3];
        dv = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h55, 8'hA3};
        sel_a = '{16'h8000, 16'h9FFE, 16'h8F10};
        dat_a = '{16'h8001, 16'h9FFF, 16'h8123};
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R9 reset");

        // select/data sweep: all indices, both order bits, aliases of the slots
        for (int hi = 0; hi < 4; hi++) begin
            for (int idx = 0; idx < 8; idx++) begin
                for (int k = 0; k < 8; k++) begin
                    wr(sel_a[k % 3], (hi << 6) | idx);
                    wr(dat_a[(k + idx) % 3], dv[k]);
                    if (idx < 2)      check_all("R1 R2 R3 R5 R6 R10");
                    else              check_all("R1 R2 R4 R5 R6 R10");
                end
            end
        end

        // idle cycles hold everything
        repeat (4) @(negedge clk);
        check_all("R11 idle");

        // mirroring
        wr(16'hA000, 8'h01); check_all("R7 horizontal");
        wr(16'hBFFE, 8'hFE); check_all("R7 vertical via alias");
        four_screen = 1'b1;
        wr(16'hA000, 8'h01); check_all("R7 strap blocks");
        four_screen = 1'b0;
        wr(16'hA000, 8'h01); check_all("R7 strap released");

        // unused decoded slots
        wr(16'hA001, 8'h00); check_all("R1 slot A001");
        wr(16'hC000, 8'hFF); check_all("R1 slot C000");
        wr(16'hC001, 8'hFF); check_all("R1 slot C001");
        wr(16'hE000, 8'hFF); check_all("R1 slot E000");
        wr(16'hFFFF, 8'hFF); check_all("R1 slot E001");
        wr(16'h4000, 8'h03); check_all("R8 below low range");
        wr(16'h40FF, 8'h03); check_all("R8 below low range edge");

        // override against swapped ordering
        wr(16'h8000, 8'h46); wr(16'h8001, 8'h09);
        wr(16'h8000, 8'h47); wr(16'h8001, 8'h0C);
        check_all("R5 swapped before override");
        for (int d = 0; d < 32; d++) begin
            wr(16'h4100 + d * 16'h01F3, d * 5 + 1);
            check_all("R8 low pair");
        end
        wr(16'h7FFF, 8'h06); check_all("R8 top of low range");
        wr(16'h8000, 8'h42); check_all("R8 select write ends override");
        wr(16'h5000, 8'h02);
        wr(16'h8001, 8'h33); check_all("R8 override survives single write");
        wr(16'hA000, 8'h00); check_all("R8 override survives mirror write");
        wr(16'hC000, 8'h00); check_all("R8 override survives ignored write");
        wr(16'h8000, 8'h07); wr(16'h6000, 8'h05);
        wr(16'h8001, 8'h03); check_all("R8 program data write ends override");
        wr(16'h6000, 8'h04);
        wr(16'h8000, 8'h06); wr(16'h8001, 8'h0A);
        check_all("R8 R4 index 6 after override");

        // reset in mid run
        do_reset();
        check_all("R9 second reset");
        repeat (3) @(negedge clk);
        check_all("R11 idle after reset");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule